// File: doc/BRIEF.md
# I2C Start Request and Reservation Controller

This block sits between a software control register and the bit-level engine of an I2C master/slave port. Software writes a start-request bit. Depending on the bus state and this device's role, the block does one of four things with it:

- issues a start condition at once;
- parks the request as a reservation and issues the start by itself after another device's stop;
- drops the request and raises a sticky flag, when reservations are switched off;
- arms a repeated start that fires once the master's wait state is released.

The bus monitor supplies the busy flag and the stop-detected pulse. The bit engine supplies the master role, the wait state and the wait-release pulse. The arbitration logic supplies the arbitration-lost pulse. An exit-communication command, arbitration loss or a disable each discard any request that is held. The start and repeated-start outputs are one-cycle strobes for the bit engine. A parameter sets how many cycles after a stop the reserved start is issued; the default is one.

Top module: `i2c_start_ctrl`

## Requirements
- R1: With `en`=1, `is_master`=0, `bus_busy`=0 and nothing held, a cycle with `wr_en`=1 and `wr_start`=1 makes `start_gen` high for exactly the next cycle.
- R2: If that write sees `bus_busy`=1 and `rsv_dis`=0, `rsv_pending` is 1 from the next cycle on. It stays 1 until the cycle after a sampled `stop_det`. In that cycle, if `bus_busy` is 0, `start_gen` pulses and `rsv_pending` drops at the following edge.
- R3: If that write sees `bus_busy`=1 and `rsv_dis`=1, no start is issued and nothing is held. `start_clr_flag` becomes 1 in the next cycle.
- R4: A write of `wr_start`=1 while `is_master`=1 and `wait_st`=1 arms a repeated start. `restart_gen` pulses in the cycle after `wait_rel` is sampled high.
- R5: A write of `wr_start`=1 while `is_master`=1 and `wait_st`=0 (transfer or acknowledge phase) is ignored. It produces no start, no repeated start and no reservation.
- R6: `arb_lost`=1 or `exit_cmd`=1 discards any held or armed request from the next cycle on, and suppresses both pulses in the same cycle. A write in that cycle is discarded.
- R7: While `en`=0, writes of `wr_start` have no effect. From the next cycle, nothing is held and `start_clr_flag` is 0.
- R8: The read-back of the request bit, `req_rd`, is always 0.
- R9: A write of `wr_start`=1 while a request is already held or armed is ignored. Only one start is ever issued for it.
- R10: `start_clr_flag` stays 1 until a cycle with `wr_en`=1 and `wr_flag_clr`=1 clears it. If the flag is set and cleared in the same cycle, the set wins.
- R11: `start_gen` and `restart_gen` are never high in the same cycle, and neither is high for two cycles in a row.
- R12: If `bus_busy` is still 1 in the cycle after the stop is sampled, no start is issued. The reservation stays held and waits for a later stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| rsv_dis | input | 1 | 1 = reservations prohibited |
| wr_en | input | 1 | Control register write strobe |
| wr_start | input | 1 | Start-request bit of the write |
| wr_flag_clr | input | 1 | Flag-clear bit of the write |
| bus_busy | input | 1 | Bus busy flag from the bus monitor |
| stop_det | input | 1 | Stop-detected pulse |
| is_master | input | 1 | This device currently owns the bus |
| wait_st | input | 1 | Master holds the clock in a wait state |
| wait_rel | input | 1 | Wait-release pulse |
| arb_lost | input | 1 | Arbitration-lost pulse |
| exit_cmd | input | 1 | Exit-communication command |
| start_gen | output | 1 | Start-condition strobe to the bit engine |
| restart_gen | output | 1 | Repeated-start strobe to the bit engine |
| rsv_pending | output | 1 | A reservation is held |
| start_clr_flag | output | 1 | Sticky flag: a request was dropped |
| req_rd | output | 1 | Read-back value of the request bit |

## Verification
The pulses follow fixed latencies:

- An immediate start is due in the cycle after the write edge.
- A reserved start is due in the cycle after the edge that samples the stop.
- A repeated start is due in the cycle after the edge that samples the wait release.

The bench drives every input at the falling edge. Each driver task records, for each pulse it expects, the index of the sampling window two windows on from its own. A monitor samples just before each rising edge and matches every pulse against that queue. Any pulse that arrives early, late, twice or of the wrong kind is reported. Status outputs are read a few time units after the falling edge that follows the stimulus edge, which is where their registered values first show.

// File: rtl/i2c_sreq_pkg.sv
package i2c_sreq_pkg;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_START,
    CLS_RESERVE,
    CLS_DROP,
    CLS_RESTART
  } req_cls_e;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_GO,
    RS_HELD,
    RS_RELEASE
  } rsv_state_e;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_ARMED,
    WR_FIRE
  } rst_state_e;

  // Classify a register write of the request bit against bus and role state.
  function automatic req_cls_e classify_req(
    input logic enable,
    input logic req_wr,
    input logic kill,
    input logic pending,
    input logic master,
    input logic in_wait,
    input logic busy,
    input logic no_rsv
  );
    req_cls_e c;
    c = CLS_NONE;
    if (enable && req_wr && !kill && !pending) begin
      if (master) begin
        if (in_wait) c = CLS_RESTART;
      end else if (!busy) begin
        c = CLS_START;
      end else if (no_rsv) begin
        c = CLS_DROP;
      end else begin
        c = CLS_RESERVE;
      end
    end
    return c;
  endfunction

  // Width of the post-stop delay counter.
  function automatic int dly_width(input int dly);
    return (dly > 1) ? $clog2(dly) : 1;
  endfunction

endpackage

// File: rtl/sreq_decode.sv
module sreq_decode
  import i2c_sreq_pkg::*;
(
  input  logic     en,
  input  logic     wr_en,
  input  logic     wr_start,
  input  logic     kill,
  input  logic     pending,
  input  logic     is_master,
  input  logic     wait_st,
  input  logic     bus_busy,
  input  logic     rsv_dis,
  output req_cls_e cls
);

  logic req_wr;

  assign req_wr = wr_en && wr_start;

  always_comb begin
    cls = classify_req(en, req_wr, kill, pending, is_master, wait_st,
                       bus_busy, rsv_dis);
  end

endmodule

// File: rtl/sreq_reserve.sv
module sreq_reserve
  import i2c_sreq_pkg::*;
#(
  parameter int REL_DELAY = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  req_cls_e cls,
  input  logic     kill,
  input  logic     stop_det,
  input  logic     bus_busy,
  output logic     start_gen,
  output logic     held,
  output logic     busy_o
);

  localparam int CW = dly_width(REL_DELAY);
  localparam logic [CW-1:0] LOAD = CW'(REL_DELAY - 1);

  rsv_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_ready;

  assign rel_ready = (st_q == RS_RELEASE) && (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (kill) begin
      st_d  = RS_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        RS_IDLE: begin
          if (cls == CLS_START)        st_d = RS_GO;
          else if (cls == CLS_RESERVE) st_d = RS_HELD;
        end
        RS_GO: st_d = RS_IDLE;
        RS_HELD: begin
          if (stop_det) begin
            st_d  = RS_RELEASE;
            cnt_d = LOAD;
          end
        end
        RS_RELEASE: begin
          if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
          else if (bus_busy) st_d  = RS_HELD;
          else               st_d  = RS_IDLE;
        end
        default: st_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign start_gen = !kill && ((st_q == RS_GO) || (rel_ready && !bus_busy));
  assign held      = (st_q == RS_HELD) || (st_q == RS_RELEASE);
  assign busy_o    = (st_q != RS_IDLE);

endmodule

// File: rtl/sreq_restart.sv
module sreq_restart
  import i2c_sreq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  req_cls_e cls,
  input  logic     kill,
  input  logic     wait_rel,
  output logic     restart_gen,
  output logic     busy_o
);

  rst_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (kill) begin
      st_d = WR_IDLE;
    end else begin
      unique case (st_q)
        WR_IDLE:  if (cls == CLS_RESTART) st_d = WR_ARMED;
        WR_ARMED: if (wait_rel)           st_d = WR_FIRE;
        WR_FIRE:  st_d = WR_IDLE;
        default:  st_d = WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WR_IDLE;
    else        st_q <= st_d;
  end

  assign restart_gen = !kill && (st_q == WR_FIRE);
  assign busy_o      = (st_q != WR_IDLE);

endmodule

// File: rtl/sreq_flag.sv
module sreq_flag
  import i2c_sreq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  req_cls_e cls,
  input  logic     clr_wr,
  output logic     flag
);

  logic set_evt;

  assign set_evt = (cls == CLS_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (!en)     flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_wr)  flag <= 1'b0;
  end

endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2c_sreq_pkg::*;
#(
  parameter int REL_DELAY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rsv_dis,
  input  logic wr_en,
  input  logic wr_start,
  input  logic wr_flag_clr,
  input  logic bus_busy,
  input  logic stop_det,
  input  logic is_master,
  input  logic wait_st,
  input  logic wait_rel,
  input  logic arb_lost,
  input  logic exit_cmd,
  output logic start_gen,
  output logic restart_gen,
  output logic rsv_pending,
  output logic start_clr_flag,
  output logic req_rd
);

  req_cls_e cls;
  logic     kill;
  logic     req_pending;
  logic     rsv_busy;
  logic     rst_busy;
  logic     flag_clr_wr;

  assign kill        = arb_lost || exit_cmd || !en;
  assign req_pending = rsv_busy || rst_busy;
  assign flag_clr_wr = wr_en && wr_flag_clr;
  assign req_rd      = 1'b0;

  sreq_decode u_dec (
    .en        (en),
    .wr_en     (wr_en),
    .wr_start  (wr_start),
    .kill      (kill),
    .pending   (req_pending),
    .is_master (is_master),
    .wait_st   (wait_st),
    .bus_busy  (bus_busy),
    .rsv_dis   (rsv_dis),
    .cls       (cls)
  );

  sreq_reserve #(.REL_DELAY(REL_DELAY)) u_rsv (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls       (cls),
    .kill      (kill),
    .stop_det  (stop_det),
    .bus_busy  (bus_busy),
    .start_gen (start_gen),
    .held      (rsv_pending),
    .busy_o    (rsv_busy)
  );

  sreq_restart u_rst (
    .clk         (clk),
    .rst_n       (rst_n),
    .cls         (cls),
    .kill        (kill),
    .wait_rel    (wait_rel),
    .restart_gen (restart_gen),
    .busy_o      (rst_busy)
  );

  sreq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .cls    (cls),
    .clr_wr (flag_clr_wr),
    .flag   (start_clr_flag)
  );

endmodule

// File: rtl/sreq_checker.sv
module sreq_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic rsv_dis,
  input logic wr_en,
  input logic wr_start,
  input logic wr_flag_clr,
  input logic bus_busy,
  input logic stop_det,
  input logic is_master,
  input logic wait_st,
  input logic arb_lost,
  input logic exit_cmd,
  input logic start_gen,
  input logic restart_gen,
  input logic rsv_pending,
  input logic start_clr_flag,
  input logic req_pending
);

  logic cut;
  logic drop_evt;

  assign cut      = arb_lost || exit_cmd || !en;
  assign drop_evt = en && wr_en && wr_start && !cut && !req_pending &&
                    !is_master && bus_busy && rsv_dis;

  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_gen && restart_gen));

  p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_gen |=> !start_gen);

  p_restart_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_gen |=> !restart_gen);

  p_drop_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> start_clr_flag);

  p_kill_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost || exit_cmd) |=> !rsv_pending);

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rsv_pending && !start_clr_flag));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_clr_flag && en && !(wr_en && wr_flag_clr)) |=> start_clr_flag);

  p_hold_until_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_pending && !stop_det && !cut && !start_gen) |=> rsv_pending);

  p_master_busy_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_start && is_master && !wait_st && !req_pending)
      |=> (!rsv_pending && !start_gen && !restart_gen));

endmodule

bind i2c_start_ctrl sreq_checker u_sreq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .en             (en),
  .rsv_dis        (rsv_dis),
  .wr_en          (wr_en),
  .wr_start       (wr_start),
  .wr_flag_clr    (wr_flag_clr),
  .bus_busy       (bus_busy),
  .stop_det       (stop_det),
  .is_master      (is_master),
  .wait_st        (wait_st),
  .arb_lost       (arb_lost),
  .exit_cmd       (exit_cmd),
  .start_gen      (start_gen),
  .restart_gen    (restart_gen),
  .rsv_pending    (rsv_pending),
  .start_clr_flag (start_clr_flag),
  .req_pending    (req_pending)
);

// File: tb/tb_i2c_start_ctrl.sv
module tb_i2c_start_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, rsv_dis = 1'b0, wr_en = 1'b0, wr_start = 1'b0;
  logic wr_flag_clr = 1'b0, bus_busy = 1'b0, stop_det = 1'b0;
  logic is_master = 1'b0, wait_st = 1'b0, wait_rel = 1'b0;
  logic arb_lost = 1'b0, exit_cmd = 1'b0;
  logic start_gen, restart_gen, rsv_pending, start_clr_flag, req_rd;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int    due;
    bit    rs;
    string tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_start_ctrl dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rsv_dis(rsv_dis), .wr_en(wr_en),
    .wr_start(wr_start), .wr_flag_clr(wr_flag_clr), .bus_busy(bus_busy),
    .stop_det(stop_det), .is_master(is_master), .wait_st(wait_st),
    .wait_rel(wait_rel), .arb_lost(arb_lost), .exit_cmd(exit_cmd),
    .start_gen(start_gen), .restart_gen(restart_gen),
    .rsv_pending(rsv_pending), .start_clr_flag(start_clr_flag),
    .req_rd(req_rd)
  );

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b at window %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Monitor: samples 3 units after each falling edge, before the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      cyc++;
      while (q.size() > 0 && q[0].due < cyc) begin
        n_chk++;
        n_err++;
        $display("FAIL %s: actual=no pulse expected=pulse in window %0d", q[0].tag, q[0].due);
        void'(q.pop_front());
      end
      if (req_rd !== 1'b0) begin
        n_chk++;
        n_err++;
        $display("FAIL R8: actual=%0b expected=0", req_rd);
      end
      if (start_gen && restart_gen) begin
        n_chk++;
        n_err++;
        $display("FAIL R11: actual=both pulses expected=at most one");
      end
      if (start_gen || restart_gen) begin
        n_chk++;
        if (q.size() == 0) begin
          n_err++;
          $display("FAIL R11: actual=unexpected %s pulse expected=none at window %0d",
                   restart_gen ? "restart" : "start", cyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.due != cyc || e.rs != restart_gen) begin
            n_err++;
            $display("FAIL %s: actual=window %0d kind %0b expected=window %0d kind %0b",
                     e.tag, cyc, restart_gen, e.due, e.rs);
          end
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic expect_pulse(int due, bit rs, string tag);
    exp_t e;
    e.due = due;
    e.rs  = rs;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic look();
    #4;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Register write; a pulse (if any) is due two windows after the drive window.
  task automatic wr(bit s, bit c, bit exp_st, bit exp_rs, string tag);
    int k;
    @(negedge clk);
    wr_en = 1'b1;
    wr_start = s;
    wr_flag_clr = c;
    k = cyc;
    if (exp_st) expect_pulse(k + 2, 1'b0, tag);
    if (exp_rs) expect_pulse(k + 2, 1'b1, tag);
    @(negedge clk);
    wr_en = 1'b0;
    wr_start = 1'b0;
    wr_flag_clr = 1'b0;
  endtask

  task automatic stop_pulse(bit busy_after, bit exp_st, string tag);
    int k;
    @(negedge clk);
    stop_det = 1'b1;
    bus_busy = busy_after;
    k = cyc;
    if (exp_st) expect_pulse(k + 2, 1'b0, tag);
    @(negedge clk);
    stop_det = 1'b0;
  endtask

  task automatic rel_pulse(bit exp_rs, string tag);
    int k;
    @(negedge clk);
    wait_rel = 1'b1;
    k = cyc;
    if (exp_rs) expect_pulse(k + 2, 1'b1, tag);
    @(negedge clk);
    wait_rel = 1'b0;
  endtask

  task automatic kill_pulse(bit use_arb);
    @(negedge clk);
    if (use_arb) arb_lost = 1'b1;
    else         exit_cmd = 1'b1;
    @(negedge clk);
    arb_lost = 1'b0;
    exit_cmd = 1'b0;
  endtask

  initial begin
    en = 1'b1;
    idle(3);
    look();
    check("R1 reset start_gen", start_gen, 1'b0);
    check("R4 reset restart_gen", restart_gen, 1'b0);
    check("R2 reset rsv_pending", rsv_pending, 1'b0);
    check("R3 reset flag", start_clr_flag, 1'b0);
    check("R8 reset req_rd", req_rd, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: immediate start on idle bus
    bus_busy = 1'b0;
    wr(1'b1, 1'b0, 1'b1, 1'b0, "R1");
    look();
    check("R1 no reservation", rsv_pending, 1'b0);
    idle(3);

    // R2: reservation, released by stop
    bus_busy = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R2");
    look();
    check("R2 held", rsv_pending, 1'b1);
    idle(4);
    look();
    check("R2 still held", rsv_pending, 1'b1);
    stop_pulse(1'b0, 1'b1, "R2");
    idle(1);
    look();
    check("R2 cleared after start", rsv_pending, 1'b0);
    idle(2);

    // R9: second write while held
    bus_busy = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R9");
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R9");
    look();
    check("R9 held once", rsv_pending, 1'b1);
    stop_pulse(1'b0, 1'b1, "R9");
    idle(4);

    // R12: stop while the bus stays busy
    bus_busy = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R12");
    stop_pulse(1'b1, 1'b0, "R12");
    idle(2);
    look();
    check("R12 still held", rsv_pending, 1'b1);
    stop_pulse(1'b0, 1'b1, "R12");
    idle(3);

    // R3: reservation prohibited
    bus_busy = 1'b1;
    rsv_dis = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    look();
    check("R3 flag set", start_clr_flag, 1'b1);
    check("R3 nothing held", rsv_pending, 1'b0);
    idle(5);
    stop_pulse(1'b0, 1'b0, "R3");
    idle(2);
    look();
    check("R10 flag sticky", start_clr_flag, 1'b1);

    // R10: clear write, then set and clear together
    wr(1'b0, 1'b1, 1'b0, 1'b0, "R10");
    look();
    check("R10 flag cleared", start_clr_flag, 1'b0);
    bus_busy = 1'b1;
    wr(1'b1, 1'b1, 1'b0, 1'b0, "R10");
    look();
    check("R10 set beats clear", start_clr_flag, 1'b1);
    wr(1'b0, 1'b1, 1'b0, 1'b0, "R10");
    rsv_dis = 1'b0;
    idle(2);

    // R4: repeated start after wait release
    is_master = 1'b1;
    wait_st = 1'b1;
    bus_busy = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R4");
    look();
    check("R4 no reservation", rsv_pending, 1'b0);
    wait_st = 1'b0;
    idle(3);
    rel_pulse(1'b1, "R4");
    idle(3);

    // R5: master outside wait period
    wait_st = 1'b0;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R5");
    look();
    check("R5 no reservation", rsv_pending, 1'b0);
    rel_pulse(1'b0, "R5");
    idle(3);

    // R6: arbitration lost drops a reservation
    is_master = 1'b0;
    bus_busy = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    kill_pulse(1'b1);
    look();
    check("R6 arb drops hold", rsv_pending, 1'b0);
    stop_pulse(1'b0, 1'b0, "R6");
    idle(3);

    // R6: exit command drops an armed repeated start
    is_master = 1'b1;
    wait_st = 1'b1;
    bus_busy = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    wait_st = 1'b0;
    kill_pulse(1'b0);
    rel_pulse(1'b0, "R6");
    idle(3);
    is_master = 1'b0;

    // R7: disable clears flag and reservation, writes have no effect
    bus_busy = 1'b1;
    rsv_dis = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    rsv_dis = 1'b0;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    look();
    check("R7 flag before disable", start_clr_flag, 1'b1);
    check("R7 held before disable", rsv_pending, 1'b1);
    @(negedge clk);
    en = 1'b0;
    idle(1);
    look();
    check("R7 flag cleared", start_clr_flag, 1'b0);
    check("R7 hold cleared", rsv_pending, 1'b0);
    bus_busy = 1'b0;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    bus_busy = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    look();
    check("R7 write ignored", rsv_pending, 1'b0);
    stop_pulse(1'b0, 1'b0, "R7");
    @(negedge clk);
    en = 1'b1;
    idle(2);

    // R1 again after re-enable, back-to-back starts
    wr(1'b1, 1'b0, 1'b1, 1'b0, "R1");
    idle(1);
    wr(1'b1, 1'b0, 1'b1, 1'b0, "R1");
    idle(6);

    n_chk++;
    if (q.size() != 0) begin
      n_err++;
      $display("FAIL R11: actual=%0d pulses outstanding expected=0", q.size());
    end
    finish_run();
  end

endmodule